// File: doc/BRIEF.md
# Integer Add Unit with Carry and Overflow Flags

This block is the add slice of a simple processor's execution stage. Each accepted operation adds a register operand to either a second register operand or a sign-extended 16-bit immediate. The two carry-in variants also add the current carry flag as a third one-bit term. Every add produces a 32-bit sum and fresh values for the unsigned carry flag and the signed overflow flag. The flags are returned with a write-enable so that the surrounding status register can take them.

When the overflow-trap enable from the status register is high and an add overflows, the unit raises a range-exception request. The request lasts one cycle and arrives together with the result. The sum and flags are still written back in that cycle. A carry out on its own never raises the request.

The unit has one register stage. Results, flags and the exception request appear on the cycle after the `valid_i` strobe. When no operation is presented, the outputs hold their last values and the write-enable stays low.

Top module: `int_add_unit`

## Requirements
- R1: With `op_i` = 2'b00 (register add) or 2'b10 (immediate add), the incoming `cy_i` has no effect on the sum or the flags. For example, 1 + 2 gives 3 with both flags clear even while `cy_i` is 1.
- R2: With `op_i` = 2'b01 (register add with carry) or 2'b11 (immediate add with carry), the value of `cy_i` is added into the sum at bit 0.
- R3: For `op_i[1]` = 1, the second operand is `imm_i` sign-extended to 32 bits. 0x8000 acts as 0xFFFF8000 and 0xFFFF acts as 0xFFFFFFFF. `opb_i` is then unused.
- R4: `cy_o` is the carry out of bit 31 of the full sum, carry-in included. For example, 0xFFFFFFFF + 0 + carry gives 0 with `cy_o`=1, in either operand order.
- R5: `ov_o` is high exactly when the two's-complement result overflows, carry-in included. For example, 0x40000000 + 0x3FFFFFFF + carry gives 0x80000000 with `ov_o`=1, and 0xC0000000 + 0xBFFFFFFF + carry gives 0x80000000 with `ov_o`=0.
- R6: `range_exc_o` is high in the result cycle only when that add overflowed and `ove_i` was 1 when the operation was accepted. A carry without overflow never raises it. It is a one-cycle pulse.
- R7: Sum, flags and `flag_we_o` = 1 appear on the first rising edge after `valid_i` is sampled high. Every add updates both flags.
- R8: In a cycle after `valid_i` was low, `flag_we_o` and `range_exc_o` are 0, and `sum_o`, `cy_o` and `ov_o` keep their previous values.
- R9: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An add operation is presented this cycle |
| op_i | input | 2 | Bit 1 selects the immediate operand; bit 0 enables carry-in |
| opa_i | input | 32 | First register operand |
| opb_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate operand, sign-extended |
| cy_i | input | 1 | Current carry flag from the status register |
| ove_i | input | 1 | Overflow-trap enable from the status register |
| sum_o | output | 32 | Registered sum |
| cy_o | output | 1 | New carry flag |
| ov_o | output | 1 | New overflow flag |
| flag_we_o | output | 1 | Write-enable for the carry and overflow flags |
| range_exc_o | output | 1 | One-cycle range-exception request |

## Verification
The bench targets the cases where the carry-in is the only thing that decides a flag.

- Adding all-ones to zero with a carry wraps to zero. A unit that derived carry from operand bits alone would leave `cy_o` clear.
- 0x40000000 + 0x3FFFFFFF + carry overflows only through the carry-in. A unit that judged overflow by operand signs alone, without the carry, would miss it and also drop the exception.
- Sets `cy_i` on the plain adds to catch a unit that always adds it.
- Applies the sign-extension boundaries 0x7FFF, 0x8000 and 0xFFFF to catch a unit that zero-extends.
- Runs carry-only results with the trap enabled to catch a unit that traps on any flag.
- Follows each exception with an idle cycle to catch a request that lingers.

// File: rtl/int_add_pkg.sv
package int_add_pkg;
  // op bit 1: immediate operand, op bit 0: carry-in enabled
  typedef enum logic [1:0] {
    ADD_RR  = 2'b00,
    ADD_RRC = 2'b01,
    ADD_RI  = 2'b10,
    ADD_RIC = 2'b11
  } add_op_e;

  typedef struct packed {
    logic cy;
    logic ov;
  } add_flags_t;
endpackage

// File: rtl/add_operand_sel.sv
module add_operand_sel
  import int_add_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  add_op_e          op_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             cy_i,
  output logic [WIDTH-1:0] b_o,
  output logic             cin_o
);
  logic [WIDTH-1:0] imm_ext;

  generate
    if (IMM_W < WIDTH) begin : g_sext
      assign imm_ext = {{(WIDTH-IMM_W){imm_i[IMM_W-1]}}, imm_i};
    end else begin : g_trunc
      assign imm_ext = imm_i[WIDTH-1:0];
    end
  endgenerate

  always_comb begin
    b_o   = (op_i == ADD_RI || op_i == ADD_RIC) ? imm_ext : opb_i;
    cin_o = (op_i == ADD_RRC || op_i == ADD_RIC) ? cy_i : 1'b0;
  end

  // R1: plain variants never pass a carry through
  always_comb begin
    if (op_i == ADD_RR || op_i == ADD_RI)
      p_no_cin_plain_r1: assert (cin_o == 1'b0);
  end
endmodule

// File: rtl/add_core.sv
module add_core #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cy_o,
  output logic             ov_o
);
  localparam int LOW_W = WIDTH - 1;

  logic [LOW_W:0] low_sum;   // top bit is carry into MSB
  logic [1:0]     msb_sum;

  // split add exposes carry-in and carry-out of the sign bit
  always_comb begin
    low_sum = {1'b0, a_i[LOW_W-1:0]} + {1'b0, b_i[LOW_W-1:0]} + {{LOW_W{1'b0}}, cin_i};
    msb_sum = {1'b0, a_i[WIDTH-1]} + {1'b0, b_i[WIDTH-1]} + {1'b0, low_sum[LOW_W]};
    sum_o   = {msb_sum[0], low_sum[LOW_W-1:0]};
    cy_o    = msb_sum[1];
    ov_o    = msb_sum[1] ^ low_sum[LOW_W];
  end

  // R4: split carry matches one wide addition
  always_comb begin
    p_carry_wide_r4: assert ({cy_o, sum_o} ==
      ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}));
  end
endmodule

// File: rtl/add_result_reg.sv
module add_result_reg
  import int_add_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] sum_i,
  input  add_flags_t       flags_i,
  input  logic             ove_i,
  output logic [WIDTH-1:0] sum_o,
  output add_flags_t       flags_o,
  output logic             we_o,
  output logic             exc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o   <= '0;
      flags_o <= '0;
      we_o    <= 1'b0;
      exc_o   <= 1'b0;
    end else begin
      we_o  <= valid_i;
      exc_o <= valid_i & ove_i & flags_i.ov;
      if (valid_i) begin
        sum_o   <= sum_i;
        flags_o <= flags_i;
      end
    end
  end
endmodule

// File: rtl/int_add_unit.sv
module int_add_unit
  import int_add_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       op_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             cy_i,
  input  logic             ove_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cy_o,
  output logic             ov_o,
  output logic             flag_we_o,
  output logic             range_exc_o
);
  add_op_e          op;
  logic [WIDTH-1:0] b_sel;
  logic             cin;
  logic [WIDTH-1:0] sum_c;
  add_flags_t       flags_c, flags_q;

  assign op = add_op_e'(op_i);

  add_operand_sel #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_sel (
    .op_i  (op),
    .opb_i (opb_i),
    .imm_i (imm_i),
    .cy_i  (cy_i),
    .b_o   (b_sel),
    .cin_o (cin)
  );

  add_core #(.WIDTH(WIDTH)) u_core (
    .a_i   (opa_i),
    .b_i   (b_sel),
    .cin_i (cin),
    .sum_o (sum_c),
    .cy_o  (flags_c.cy),
    .ov_o  (flags_c.ov)
  );

  add_result_reg #(.WIDTH(WIDTH)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .sum_i   (sum_c),
    .flags_i (flags_c),
    .ove_i   (ove_i),
    .sum_o   (sum_o),
    .flags_o (flags_q),
    .we_o    (flag_we_o),
    .exc_o   (range_exc_o)
  );

  assign cy_o = flags_q.cy;
  assign ov_o = flags_q.ov;

  p_we_follows_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> flag_we_o);
  p_idle_no_we_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !flag_we_o && !range_exc_o);
  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(sum_o) && $stable(cy_o) && $stable(ov_o));
  p_exc_needs_ov_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    range_exc_o |-> ov_o && flag_we_o);
  p_exc_needs_ove_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !ove_i |=> !range_exc_o);
endmodule

// File: tb/sim_int_add_unit.sv
module sim_int_add_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] opa = '0, opb = '0;
  logic [15:0] imm = '0;
  logic        cy = 1'b0, ove = 1'b0;
  logic [31:0] sum;
  logic        cy_q, ov_q, we, exc;
  int checks = 0, failures = 0, cycles = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  int_add_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .opa_i(opa), .opb_i(opb), .imm_i(imm), .cy_i(cy), .ove_i(ove),
    .sum_o(sum), .cy_o(cy_q), .ov_o(ov_q), .flag_we_o(we), .range_exc_o(exc)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one add, checked against a sign-comparison model
  task automatic run_add(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic c, input logic e, input string req);
    logic [31:0] bop;
    logic [32:0] full;
    logic        e_ov, e_exc;
    bop   = o[1] ? {{16{im[15]}}, im} : b;
    full  = {1'b0, a} + {1'b0, bop} + {32'd0, (o[0] & c)};
    e_ov  = (a[31] == bop[31]) && (full[31] != a[31]);
    e_exc = e_ov & e;
    @(negedge clk);
    valid = 1'b1; op = o; opa = a; opb = b; imm = im; cy = c; ove = e;
    @(negedge clk);
    valid = 1'b0;
    chk(sum == full[31:0], {req, " sum"}, sum, full[31:0]);
    chk(cy_q == full[32], {req, " cy"}, 32'(cy_q), 32'(full[32]));
    chk(ov_q == e_ov, {req, " ov"}, 32'(ov_q), 32'(e_ov));
    chk(we == 1'b1, "R7 flag_we", 32'(we), 32'd1);
    chk(exc == e_exc, {req, " exc"}, 32'(exc), 32'(e_exc));
  endtask

  task automatic idle_hold(input string req);
    logic [31:0] s0;
    logic c0, v0;
    s0 = sum; c0 = cy_q; v0 = ov_q;
    @(negedge clk);
    valid = 1'b0; cy = ~cy; opa = ~opa;
    @(negedge clk);
    chk(we == 1'b0, {req, " we idle"}, 32'(we), 32'd0);
    chk(exc == 1'b0, {req, " exc pulse ends"}, 32'(exc), 32'd0);
    chk(sum == s0 && cy_q == c0 && ov_q == v0, {req, " hold"}, sum, s0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sum == 0 && cy_q == 0 && ov_q == 0 && we == 0 && exc == 0, "R9 reset", sum, 32'd0);
    rst_n = 1'b1;
    // R1: carry flag ignored by plain adds
    run_add(2'b00, 32'd1, 32'd2, 16'h0, 1'b1, 1'b0, "R1 rr cy set");
    run_add(2'b10, 32'd1, 32'd0, 16'd2, 1'b1, 1'b0, "R1 ri cy set");
    // R4/R5 register add corners
    run_add(2'b00, 32'hFFFFFFFF, 32'hFFFFFFFE, 16'h0, 1'b0, 1'b0, "R4 neg small");
    run_add(2'b00, 32'h40000000, 32'h3FFFFFFF, 16'h0, 1'b0, 1'b0, "R5 no ov");
    run_add(2'b00, 32'h40000000, 32'h40000000, 16'h0, 1'b0, 1'b0, "R5 pos ov");
    run_add(2'b00, 32'hC0000000, 32'hC0000000, 16'h0, 1'b0, 1'b0, "R4 neg cy");
    run_add(2'b00, 32'hBFFFFFFF, 32'hBFFFFFFF, 16'h0, 1'b0, 1'b0, "R5 both");
    // R2: carry-in variants
    run_add(2'b01, 32'h40000000, 32'h3FFFFFFF, 16'h0, 1'b1, 1'b0, "R2 cin ov");
    run_add(2'b01, 32'hFFFFFFFF, 32'h00000000, 16'h0, 1'b1, 1'b0, "R4 wrap ab");
    run_add(2'b01, 32'h00000000, 32'hFFFFFFFF, 16'h0, 1'b1, 1'b0, "R4 wrap ba");
    run_add(2'b01, 32'hC0000000, 32'hBFFFFFFF, 16'h0, 1'b1, 1'b0, "R5 cin avoids ov");
    // R3: sign-extended immediates
    run_add(2'b10, 32'h7FFF8000, 32'h0, 16'h7FFF, 1'b0, 1'b0, "R3 imm 7fff");
    run_add(2'b10, 32'h80008000, 32'h0, 16'h8000, 1'b0, 1'b0, "R3 imm 8000");
    run_add(2'b11, 32'h00000000, 32'h0, 16'hFFFF, 1'b1, 1'b0, "R3 imm ffff cin");
    run_add(2'b11, 32'h7FFF8000, 32'h0, 16'h7FFF, 1'b1, 1'b0, "R2 immc ov");
    run_add(2'b11, 32'h80007FFF, 32'h0, 16'h8000, 1'b1, 1'b0, "R2 immc no ov");
    // R6: range exceptions
    run_add(2'b00, 32'h40000000, 32'h40000000, 16'h0, 1'b0, 1'b1, "R6 ov trap");
    idle_hold("R8");
    run_add(2'b00, 32'hFFFFFFFF, 32'hFFFFFFFE, 16'h0, 1'b0, 1'b1, "R6 carry only");
    run_add(2'b01, 32'h40000000, 32'h3FFFFFFF, 16'h0, 1'b1, 1'b1, "R6 cin ov trap");
    idle_hold("R6");
    run_add(2'b11, 32'h7FFFC000, 32'h0, 16'h3FFF, 1'b1, 1'b1, "R6 immc trap");
    run_add(2'b10, 32'h80007FFF, 32'h0, 16'h8000, 1'b0, 1'b1, "R6 both trap");
    run_add(2'b01, 32'h00000000, 32'hFFFFFFFF, 16'h0, 1'b1, 1'b1, "R6 cy no trap");
    run_add(2'b00, 32'hBFFFFFFF, 32'hBFFFFFFF, 16'h0, 1'b0, 1'b0, "R6 ove off");
    idle_hold("R8 final");
    // R9: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(sum == 0 && cy_q == 0 && ov_q == 0 && we == 0 && exc == 0, "R9 re-reset", sum, 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule